// File: doc/BRIEF.md
# Selectable Serial Line Code Encoder

This block turns a serial bit stream into a single coded line output. Each bit is offered on a valid/ready handshake, and the block spends one bit cell on it. A 3-bit mode field picks the code: level-based NRZ, transition-based NRZI, the biphase codes FM0 and FM1, or Manchester. An invert control flips the polarity of the line. The block runs on a clock at twice the bit rate. A bit cell is always two clock cycles long, a first half and a second half, which lets the biphase codes place an edge in the middle of the cell.

The handshake works as follows. `bit_ready` is high for exactly one cycle per cell: the first-half slot at the cell boundary. A bit is taken on the rising edge where `bit_valid` and `bit_ready` are both high. If the source has nothing ready at a boundary, the cell is still sent as an idle cell. The source applies back-pressure only by holding `bit_valid` low, and it must keep a pending bit stable until the edge that accepts it. The mode and invert controls are sampled on the same boundary edge and are held for the whole cell. An internal tracking level is the uninverted line level at the end of the last cell. NRZI, FM0 and FM1 build on it, and reset clears it to 0.

Top module: `line_encoder`

## Requirements
- R1: After reset, `line_out` is 0 and `bit_ready` is 1.
- R2: `bit_ready` is 1 in the cycle before each cell's first-half edge and 0 in the cycle before its second-half edge. It therefore alternates every cycle, and a bit is accepted on an edge where `bit_valid` and `bit_ready` are both 1.
- R3: In mode 3'b000 (NRZ), an accepted bit drives the line to the bit's value for both halves of the cell.
- R4: In mode 3'b001 (NRZI), an accepted 0 inverts the tracking level for the whole cell, and an accepted 1 keeps it.
- R5: In mode 3'b010 (FM0), the first half is the inverse of the tracking level. A 0 adds a second toggle in the second half, and a 1 holds the first-half level.
- R6: In mode 3'b011 (FM1), the first half is the inverse of the tracking level. A 1 adds a second toggle in the second half, and a 0 holds the first-half level.
- R7: In mode 3'b100 (Manchester), a 1 is sent as high then low, and a 0 as low then high.
- R8: A cell with no accepted bit holds the tracking level in NRZ and NRZI, and is coded as a 1 in FM0, FM1 and Manchester.
- R9: Mode values 3'b101, 3'b110 and 3'b111 code exactly as NRZ.
- R10: With `invert` high for a cell, both halves of `line_out` are the XOR-inverse of the coded level. The tracking level stays uninverted.
- R11: Mode, invert and data are sampled only at the cell boundary. Changing them during the second half does not alter that cell's output.
- R12: The tracking level is 0 after reset, so the first FM0 cell after reset starts high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A data bit is offered |
| bit_ready | output | 1 | Cell boundary slot; the offered bit is taken on this edge |
| bit_data | input | 1 | Data bit value |
| mode | input | 3 | Line code select |
| invert | input | 1 | Invert output polarity for the cell |
| line_out | output | 1 | Coded line level |

## Verification
A bit taken on boundary edge E sets `line_out` right after E for the first half. The second-half level appears right after E+1, and `bit_ready` is high again in the same cycle. The bench drives inputs on falling edges. It samples the first-half level at the next falling edge and the second-half level at the one after that, then offers the next cell. Between those two samples it scrambles mode, invert and data, so every cell also checks that the second half ignores them. A model in the bench tracks the uninverted end-of-cell level from the requirements, so each cell's expected halves depend on the history before it.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LC_NRZ   = 3'd0,
    LC_NRZI  = 3'd1,
    LC_FM0   = 3'd2,
    LC_FM1   = 3'd3,
    LC_MANCH = 3'd4
  } line_code_e;

  typedef struct packed {
    logic first;
    logic second;
  } cell_lvl_t;
endpackage

// File: rtl/line_phase_ctr.sv
module line_phase_ctr #(
  parameter logic START_PHASE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic at_boundary
);
  logic second_half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) second_half_q <= START_PHASE;
    else        second_half_q <= ~second_half_q;
  end

  assign at_boundary = ~second_half_q;
endmodule

// File: rtl/line_cell_coder.sv
module line_cell_coder
  import line_enc_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic [MW-1:0] mode,
  input  logic          have_bit,
  input  logic          data,
  input  logic          track_lvl,
  output cell_lvl_t     lvl
);
  logic biphase_bit;

  // idle biphase cells carry a 1
  assign biphase_bit = have_bit ? data : 1'b1;

  always_comb begin
    lvl.first  = track_lvl;
    lvl.second = track_lvl;
    case (mode)
      LC_NRZI: begin
        lvl.first  = (have_bit && !data) ? ~track_lvl : track_lvl;
        lvl.second = lvl.first;
      end
      LC_FM0: begin
        lvl.first  = ~track_lvl;
        lvl.second = biphase_bit ? lvl.first : ~lvl.first;
      end
      LC_FM1: begin
        lvl.first  = ~track_lvl;
        lvl.second = biphase_bit ? ~lvl.first : lvl.first;
      end
      LC_MANCH: begin
        lvl.first  = biphase_bit;
        lvl.second = ~biphase_bit;
      end
      default: begin
        lvl.first  = have_bit ? data : track_lvl;
        lvl.second = lvl.first;
      end
    endcase
  end
endmodule

// File: rtl/line_half_out.sv
module line_half_out
  import line_enc_pkg::*;
#(
  parameter logic RESET_LVL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      at_boundary,
  input  cell_lvl_t lvl,
  input  logic      invert,
  output logic      track_lvl,
  output logic      inv_q,
  output logic      line_q
);
  logic second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_lvl <= RESET_LVL;
      inv_q     <= 1'b0;
      second_q  <= RESET_LVL;
      line_q    <= RESET_LVL;
    end else if (at_boundary) begin
      track_lvl <= lvl.second;
      inv_q     <= invert;
      second_q  <= lvl.second ^ invert;
      line_q    <= lvl.first ^ invert;
    end else begin
      line_q    <= second_q;
    end
  end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_enc_pkg::*;
#(
  parameter int unsigned MW        = MODE_W,
  parameter logic        RESET_LVL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  output logic          bit_ready,
  input  logic          bit_data,
  input  logic [MW-1:0] mode,
  input  logic          invert,
  output logic          line_out
);
  logic      at_boundary;
  logic      track_lvl;
  logic      inv_q;
  cell_lvl_t cell_lvl;

  line_phase_ctr #(.START_PHASE(1'b0)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .at_boundary(at_boundary)
  );

  line_cell_coder #(.MW(MW)) u_coder (
    .mode     (mode),
    .have_bit (bit_valid),
    .data     (bit_data),
    .track_lvl(track_lvl),
    .lvl      (cell_lvl)
  );

  line_half_out #(.RESET_LVL(RESET_LVL)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .at_boundary(at_boundary),
    .lvl        (cell_lvl),
    .invert     (invert),
    .track_lvl  (track_lvl),
    .inv_q      (inv_q),
    .line_q     (line_out)
  );

  assign bit_ready = at_boundary;
endmodule

// File: rtl/line_encoder_chk.sv
module line_encoder_chk #(
  parameter int unsigned MW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_valid,
  input logic          bit_ready,
  input logic          bit_data,
  input logic [MW-1:0] mode,
  input logic          invert,
  input logic          line_out,
  input logic          inv_q
);
  logic fm_sel;
  assign fm_sel = (mode == 3'd2) || (mode == 3'd3);

  AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |=> !bit_ready); // R2
  AST_READY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready |=> bit_ready); // R2
  AST_NRZ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && bit_valid && mode == 3'd0) |=> (line_out == $past(bit_data ^ invert))); // R3
  AST_NRZI_ONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && bit_valid && bit_data && mode == 3'd1 && invert == inv_q)
      |=> (line_out == $past(line_out))); // R4
  AST_FM_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && fm_sel && invert == inv_q) |=> (line_out != $past(line_out))); // R5
  AST_MANCH_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && mode == 3'd4) |=> ##1 (line_out != $past(line_out))); // R7
  AST_SPARE_AS_NRZ: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && bit_valid && mode >= 3'd5) |=> (line_out == $past(bit_data ^ invert))); // R9
endmodule

bind line_encoder line_encoder_chk #(.MW(MW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .bit_data (bit_data),
  .mode     (mode),
  .invert   (invert),
  .line_out (line_out),
  .inv_q    (inv_q)
);

// File: tb/line_encoder_test.sv
`timescale 1ns/1ps
module line_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_ready;
  logic       bit_data = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       invert = 1'b0;
  logic       line_out;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic track_m = 1'b0;

  always #4 clk = ~clk;

  line_encoder uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .mode(mode), .invert(invert), .line_out(line_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  // expected uninverted halves from the requirements
  task automatic model(input logic [2:0] m, input logic v, input logic d,
                       input logic prev, output logic h1, output logic h2);
    logic b;
    b = v ? d : 1'b1;
    case (m)
      3'd1: begin h1 = (v && !d) ? !prev : prev; h2 = h1; end
      3'd2: begin h1 = !prev; h2 = b ? h1 : !h1; end
      3'd3: begin h1 = !prev; h2 = b ? !h1 : h1; end
      3'd4: begin h1 = b; h2 = !b; end
      default: begin h1 = v ? d : prev; h2 = h1; end
    endcase
  endtask

  task automatic send_cell(input logic [2:0] m, input logic v, input logic d, input logic i);
    logic h1, h2;
    string tag;
    chk(bit_ready, 1'b1, "R2 boundary");
    bit_valid = v; bit_data = d; mode = m; invert = i;
    model(m, v, d, track_m, h1, h2);
    tag = {mode_tag(m), v ? "" : " R8", i ? " R10" : ""};
    @(negedge clk);
    chk(line_out, h1 ^ i, {tag, " first half"});
    chk(bit_ready, 1'b0, "R2 second slot");
    mode = ~m; invert = ~i; bit_data = ~d;
    @(negedge clk);
    chk(line_out, h2 ^ i, {tag, " R11 second half"});
    track_m = h2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_out, 1'b0, "R1 line at reset");
    chk(bit_ready, 1'b1, "R1 ready at reset");
    rst_n = 1'b1;
    // R12: first FM0 cell starts high from a zero tracking level
    bit_valid = 1'b1; bit_data = 1'b1; mode = 3'd2; invert = 1'b0;
    @(negedge clk);
    chk(line_out, 1'b1, "R12 first FM0 half");
    @(negedge clk);
    chk(line_out, 1'b1, "R12 FM0 one second half");
    track_m = 1'b1;
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < 64; k++) begin
        logic [5:0] idx;
        idx = 6'((k * 37 + rep * 11) % 64);
        send_cell(idx[4:2], idx[1], idx[0], idx[5]);
      end
    end
    // long NRZI runs of zeros and ones
    for (int k = 0; k < 8; k++) send_cell(3'd1, 1'b1, k[2], 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule